// File: doc/BRIEF.md
# EFM Frame Sync Detector with Flywheel

This block sits in the playback bit-clock domain of an optical-disc front end. It takes a stream of recovered channel bits and searches it for the frame sync marker. The marker is a run of eleven equal bits followed at once by eleven bits of the opposite value. A frame position counter predicts where the next marker should end. While the block is locked it produces a frame strobe at every predicted boundary. If the marker is missing or misplaced, it puts in a synthetic strobe, so that downstream demodulation keeps a steady frame grid. A match monitor goes high when a real marker lands exactly on the predicted bit, and it holds that level until the next frame boundary.

Channel bits enter through a valid/ready pair. The block never applies back-pressure: `bit_ready` is constant high, and a cycle with `bit_valid` low neither shifts the history nor moves the frame counter. A second, free-running divider on the crystal clock produces a reference frame strobe, which rate control can compare against the playback frames.

Top module: `efm_frame_sync`

## Requirements
- R1: After reset, `frame_strobe`, `frame_interp`, `sync_match`, `locked` and `ref_strobe` are low, and `bit_ready` is high.
- R2: A sync is seen on an accepted bit when that bit and the 21 accepted bits before it form 11 ones followed by 11 zeros, or 11 zeros followed by 11 ones (oldest bit first). No sync is seen until at least 22 bits have been accepted since reset.
- R3: While unlocked, a seen sync makes `frame_strobe` pulse in the cycle after the accepting edge, sets `locked`, and leaves `sync_match` low.
- R4: While locked, the predicted boundary is the 588th accepted bit after the previous boundary. A sync seen on exactly that bit gives a strobe, and `sync_match` goes high.
- R5: `sync_match` changes only together with a `frame_strobe`. It keeps its value from one boundary to the next, which is one full frame.
- R6: While locked, if no sync is seen on the predicted bit, a synthetic strobe is issued on that bit with `frame_interp` high and `sync_match` low.
- R7: While locked, a sync seen 1 or 2 bits before the predicted bit is accepted. The strobe comes on that bit, the frame grid realigns to it, and `sync_match` is low.
- R8: While locked, a sync seen more than 2 bits before, or any bit after, the predicted bit is ignored. It gives no strobe and does not move the grid.
- R9: On the third consecutive synthetic strobe, `locked` falls together with that strobe. No further strobes follow until a sync is seen, which re-acquires as in R3. Any accepted sync clears the run of misses.
- R10: `ref_strobe` is a one-cycle pulse every 2304 cycles of `xclk`.
- R11: `frame_strobe` is a one-cycle pulse. Cycles with `bit_valid` low do not advance the frame position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Playback bit clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bit_valid | input | 1 | Channel bit present on `bit_in` |
| bit_ready | output | 1 | Always high; the block takes one bit per cycle |
| bit_in | input | 1 | Channel bit |
| xclk | input | 1 | Crystal reference clock |
| frame_strobe | output | 1 | Frame boundary pulse, real or synthetic |
| frame_interp | output | 1 | Marks a synthetic boundary |
| sync_match | output | 1 | Sync coincided with prediction; held for one frame |
| locked | output | 1 | Flywheel is tracking a frame grid |
| ref_strobe | output | 1 | Crystal-derived reference frame pulse (xclk domain) |

## Verification
The assertions assume that real markers never appear on adjacent accepted bits, and that a marker cannot land on the bit directly after a boundary. Legal run lengths rule out both cases. The stimulus builds every frame from one marker and a filler of three-bit runs, so no false marker can form. The stream also inserts idle cycles at a fixed rate, which shows that stalls do not move the frame grid.

// File: rtl/efm_sync_pkg.sv
package efm_sync_pkg;
  // Kind of frame-boundary decision taken on an accepted channel bit.
  typedef enum logic [2:0] {
    EV_NONE,
    EV_ACQUIRE,
    EV_HIT,
    EV_EARLY,
    EV_INTERP
  } sync_ev_e;
endpackage

// File: rtl/efm_sync_pattern.sv
module efm_sync_pattern #(
  parameter int RUN_LEN        = 11,
  parameter bit ACCEPT_INVERSE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  output logic sync_det
);
  localparam int WIN  = 2 * RUN_LEN;
  localparam int HIST = WIN - 1;
  localparam int FW   = $clog2(WIN);
  localparam logic [WIN-1:0] PAT_POS = {{RUN_LEN{1'b1}}, {RUN_LEN{1'b0}}};

  logic [HIST-1:0] hist_q;
  logic [FW-1:0]   fill_q;
  logic [WIN-1:0]  window;
  logic            pat_hit;

  assign window = {hist_q, bit_in};

  generate
    if (ACCEPT_INVERSE) begin : g_both
      assign pat_hit = (window == PAT_POS) || (window == ~PAT_POS);
    end else begin : g_pos
      assign pat_hit = (window == PAT_POS);
    end
  endgenerate

  // History must be filled with real bits before a match counts.
  assign sync_det = bit_valid && pat_hit && (fill_q == FW'(HIST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (bit_valid) begin
      hist_q <= window[HIST-1:0];
      if (fill_q != FW'(HIST)) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/efm_flywheel_ctl.sv
module efm_flywheel_ctl
  import efm_sync_pkg::*;
#(
  parameter int FRAME_LEN  = 588,
  parameter int WINDOW     = 2,
  parameter int MISS_LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic sync_det,
  output logic frame_strobe,
  output logic frame_interp,
  output logic sync_match,
  output logic locked
);
  localparam int CW     = $clog2(FRAME_LEN);
  localparam int LAST   = FRAME_LEN - 1;
  localparam int WIN_LO = LAST - WINDOW;
  localparam int MW     = $clog2(MISS_LIMIT + 1);

  logic [CW-1:0] pos_q;
  logic [MW-1:0] miss_q;
  logic          at_pred, in_win;
  sync_ev_e      ev;

  assign at_pred = (pos_q == CW'(LAST));
  assign in_win  = (pos_q >= CW'(WIN_LO));

  always_comb begin
    ev = EV_NONE;
    if (bit_valid) begin
      if (!locked) begin
        if (sync_det) ev = EV_ACQUIRE;
      end else if (sync_det && at_pred) begin
        ev = EV_HIT;
      end else if (sync_det && in_win) begin
        ev = EV_EARLY;
      end else if (at_pred) begin
        ev = EV_INTERP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q        <= '0;
      miss_q       <= '0;
      locked       <= 1'b0;
      sync_match   <= 1'b0;
      frame_strobe <= 1'b0;
      frame_interp <= 1'b0;
    end else begin
      frame_strobe <= (ev != EV_NONE);
      frame_interp <= (ev == EV_INTERP);
      if (bit_valid) begin
        if (ev != EV_NONE || at_pred) pos_q <= '0;
        else                          pos_q <= pos_q + 1'b1;
      end
      if (ev != EV_NONE) sync_match <= (ev == EV_HIT);
      case (ev)
        EV_ACQUIRE: begin
          locked <= 1'b1;
          miss_q <= '0;
        end
        EV_HIT, EV_EARLY: miss_q <= '0;
        EV_INTERP: begin
          if (miss_q == MW'(MISS_LIMIT - 1)) begin
            miss_q <= '0;
            locked <= 1'b0;
          end else begin
            miss_q <= miss_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/efm_ref_divider.sv
module efm_ref_divider #(
  parameter int DIV = 2304
) (
  input  logic xclk,
  input  logic rst_n,
  output logic ref_strobe
);
  localparam int DW = $clog2(DIV);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge xclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      ref_strobe <= 1'b0;
    end else begin
      ref_strobe <= (cnt_q == DW'(DIV - 1));
      if (cnt_q == DW'(DIV - 1)) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/efm_frame_sync.sv
module efm_frame_sync #(
  parameter int FRAME_LEN  = 588,
  parameter int RUN_LEN    = 11,
  parameter int WINDOW     = 2,
  parameter int MISS_LIMIT = 3,
  parameter int XTAL_DIV   = 2304
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  output logic bit_ready,
  input  logic bit_in,
  input  logic xclk,
  output logic frame_strobe,
  output logic frame_interp,
  output logic sync_match,
  output logic locked,
  output logic ref_strobe
);
  logic sync_det;

  assign bit_ready = 1'b1;

  efm_sync_pattern #(.RUN_LEN(RUN_LEN), .ACCEPT_INVERSE(1'b1)) u_pat (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_valid(bit_valid),
    .bit_in   (bit_in),
    .sync_det (sync_det)
  );

  efm_flywheel_ctl #(
    .FRAME_LEN (FRAME_LEN),
    .WINDOW    (WINDOW),
    .MISS_LIMIT(MISS_LIMIT)
  ) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_valid   (bit_valid),
    .sync_det    (sync_det),
    .frame_strobe(frame_strobe),
    .frame_interp(frame_interp),
    .sync_match  (sync_match),
    .locked      (locked)
  );

  efm_ref_divider #(.DIV(XTAL_DIV)) u_ref (
    .xclk      (xclk),
    .rst_n     (rst_n),
    .ref_strobe(ref_strobe)
  );
endmodule

// File: rtl/efm_frame_sync_chk.sv
module efm_frame_sync_chk (
  input logic clk,
  input logic xclk,
  input logic rst_n,
  input logic bit_valid,
  input logic frame_strobe,
  input logic frame_interp,
  input logic sync_match,
  input logic locked,
  input logic ref_strobe
);
  AST_MATCH_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sync_match) |-> frame_strobe); // R5
  AST_INTERP_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_interp |-> (frame_strobe && !sync_match)); // R6
  AST_ACQUIRE_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (frame_strobe && !sync_match)); // R3
  AST_MATCH_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    sync_match |-> locked); // R9
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> !frame_strobe); // R11
  AST_STROBE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> $past(bit_valid)); // R11
  AST_LOCK_FALL_INTERP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> frame_interp); // R9
  AST_REF_ONE_CYCLE: assert property (@(posedge xclk) disable iff (!rst_n)
    ref_strobe |=> !ref_strobe); // R10
endmodule

bind efm_frame_sync efm_frame_sync_chk u_chk (
  .clk         (clk),
  .xclk        (xclk),
  .rst_n       (rst_n),
  .bit_valid   (bit_valid),
  .frame_strobe(frame_strobe),
  .frame_interp(frame_interp),
  .sync_match  (sync_match),
  .locked      (locked),
  .ref_strobe  (ref_strobe)
);

// File: tb/efm_frame_sync_tb.sv
module efm_frame_sync_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int XCLK_PERIOD = 4;
  localparam int REF_DIV     = 2304;
  localparam int NSYNC       = 16;
  localparam int NEV         = 21;
  localparam int STREAM_LEN  = 11230;

  logic clk = 1'b0, xclk = 1'b0, rst_n = 1'b0;
  logic bit_valid = 1'b0, bit_in = 1'b0;
  logic bit_ready, frame_strobe, frame_interp, sync_match, locked, ref_strobe;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(XCLK_PERIOD/2) xclk = ~xclk;

  efm_frame_sync u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_in(bit_in), .xclk(xclk), .frame_strobe(frame_strobe),
    .frame_interp(frame_interp), .sync_match(sync_match), .locked(locked),
    .ref_strobe(ref_strobe)
  );

  // Real sync end positions; the one at 1197 is the inverse polarity.
  int sync_end [NSYNC] = '{21, 609, 1197, 1785, 2961, 3548, 4136, 6488,
                           7076, 7674, 8262, 8850, 9438, 10024, 10609, 11200};
  // Expected boundaries: bit index, synthetic flag, match and lock after it.
  int ev_pos [NEV] = '{21, 609, 1197, 1785, 2373, 2961, 3548, 4136, 4724, 5312,
                       5900, 6488, 7076, 7664, 8252, 8840, 8850, 9438, 10024,
                       10612, 11200};
  bit ev_int [NEV] = '{0,0,0,0,1,0,0,0,1,1,1,0,0,1,1,1,0,0,0,1,0};
  bit ev_mat [NEV] = '{0,1,1,1,0,1,0,1,0,0,0,0,1,0,0,0,0,1,0,0,1};
  bit ev_lck [NEV] = '{1,1,1,1,1,1,1,1,1,1,0,1,1,1,1,0,1,1,1,1,1};
  string ev_tag [NEV] = '{"R3", "R4", "R2", "R4", "R6", "R4", "R7", "R4", "R6",
                          "R6", "R9", "R9", "R4", "R8", "R8", "R9", "R9", "R4",
                          "R7", "R8", "R4"};

  function automatic logic bit_at(int p);
    for (int k = 0; k < NSYNC; k++) begin
      if (p >= sync_end[k] - 21 && p <= sync_end[k]) begin
        if (sync_end[k] == 1197) return (p > sync_end[k] - 11);
        return (p <= sync_end[k] - 11);
      end
    end
    return ((p / 3) % 2) == 0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference strobe spacing, xclk domain.
  initial begin
    int since = 0;
    int pulses = 0;
    @(posedge rst_n);
    while (!done) begin
      @(negedge xclk);
      since++;
      if (ref_strobe) begin
        if (pulses > 0) check(since == REF_DIV, "R10", "ref_strobe spacing", since, REF_DIV);
        pulses++;
        since = 0;
      end
    end
    check(pulses >= 5, "R10", "ref_strobe pulse count", pulses, 5);
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
    $finish;
  end

  initial begin
    int idx = 0, last_acc = -1, ev_i = 0, hold_err = 0, cyc = 0;
    bit exp_m = 0, exp_l = 0, prev_s = 0;
    repeat (3) @(negedge clk);
    check(!frame_strobe && !frame_interp && !sync_match && !locked && !ref_strobe,
          "R1", "outputs in reset", {frame_strobe, frame_interp, sync_match, locked}, 0);
    rst_n = 1'b1;
    check(bit_ready, "R1", "bit_ready", bit_ready, 1);
    while (idx < STREAM_LEN || cyc < 3) begin
      @(negedge clk);
      if (frame_strobe) begin
        if (prev_s) check(0, "R11", "strobe wider than one cycle", 2, 1);
        if (ev_i < NEV) begin
          check(last_acc == ev_pos[ev_i] && frame_interp == ev_int[ev_i] &&
                sync_match == ev_mat[ev_i] && locked == ev_lck[ev_i],
                ev_tag[ev_i], "boundary bit/interp/match/lock",
                last_acc * 1000 + {frame_interp, sync_match, locked},
                ev_pos[ev_i] * 1000 + {ev_int[ev_i], ev_mat[ev_i], ev_lck[ev_i]});
          exp_m = ev_mat[ev_i];
          exp_l = ev_lck[ev_i];
          ev_i++;
        end else begin
          check(0, "R8", "unexpected strobe at bit", last_acc, -1);
        end
      end else if (frame_interp) begin
        hold_err++;
      end
      if (sync_match != exp_m || locked != exp_l) hold_err++;
      prev_s = frame_strobe;
      if (idx >= STREAM_LEN) begin
        bit_valid = 1'b0;
        cyc++;
      end else if (cyc % 13 == 12) begin
        bit_valid = 1'b0;
        cyc++;
      end else begin
        bit_valid = 1'b1;
        bit_in = bit_at(idx);
        last_acc = idx;
        idx++;
        cyc++;
      end
    end
    check(hold_err == 0, "R5", "match/lock held between boundaries", hold_err, 0);
    check(ev_i == NEV, "R11", "boundaries seen with stalls", ev_i, NEV);
    done = 1'b1;
    repeat (REF_DIV / 2) @(negedge xclk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule